// File: doc/BRIEF.md
# MESI Snoopy Cache Line Controller

This block keeps one small direct-mapped, write-back cache coherent with its peers on a shared atomic bus. It uses a four-state write-invalidate scheme. Every line is Modified, Exclusive, Shared or Invalid. Modified is the dirty state. Clean lines are either Exclusive (no other copy exists) or Shared (other copies may exist).

The CPU side is a simple request/done port. A read hit, or a write hit on an Exclusive or Modified line, completes in the request cycle and uses no bus. Every other access needs the bus, so the controller requests it. Once granted, it holds the bus for the whole sequence: an optional write-back of a dirty victim, then one miss or invalidate command, then release.

At the same time, the controller watches the commands that other caches put on the bus. When it holds the only Modified copy, it supplies that data. It also raises the shared line when it keeps a copy of a block that another cache reads. The tag array has one lookup port, and snooping wins it over the CPU.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: `bus_req`, `bus_cmd_o`, `cpu_done`, `shared_o` and `supply_o` are 0, and the first access to any address misses.
- R2: A read hit in any valid state asserts `cpu_done` in the request cycle with the line data on `cpu_rdata`, and issues no bus command.
- R3: Bus command encoding is 0 idle, 1 read miss, 2 write miss, 3 invalidate, 4 write-back. A read miss issues command 1, and a write miss issues command 2 and leaves the line Modified. No command is driven unless `bus_gnt` is high.
- R4: A write hit on an Exclusive or Modified line updates the data and leaves the line Modified, with no bus command.
- R5: A write hit on a Shared line issues only command 3 (no data is read), then leaves the line Modified.
- R6: A read miss fills from `bus_rdata_i`. The line enters Shared if `shared_i` is high in the transfer cycle, and Exclusive otherwise.
- R7: While `bus_gnt` is high, commands on the snoop inputs are ignored, including the controller's own commands mirrored back. `shared_o` and `supply_o` stay 0.
- R8: When a miss replaces a Modified line, command 4 (with the victim address and data) comes first, and the miss command follows in the next cycle. `bus_req` stays high from request through the miss command and falls once `cpu_done` has been given.
- R9: A snooped read or write miss that hits a Modified line asserts `supply_o` with the line data on `supply_data_o`. A snooped read miss then leaves the line Shared, and a snooped write miss leaves it Invalid.
- R10: A snooped read miss that hits any valid line asserts `shared_o` and moves Exclusive to Shared. A snooped write miss or invalidate moves a valid line to Invalid. A snoop whose tag does not match the stored line has no effect. The index is the low address bits.
- R11: When a snoop command (1, 2 or 3) is present while the bus is not granted, a CPU request in that cycle is stalled (`cpu_done` is 0). It completes in the first cycle without a snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| bus_req | output | 1 | Bus request, held for the whole atomic sequence |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_cmd_o | output | 3 | Command driven as bus master |
| bus_addr_o | output | ADDR_W | Address of the driven command |
| bus_data_o | output | DATA_W | Victim data during write-back |
| bus_rdata_i | input | DATA_W | Block returned by memory or a supplying cache |
| shared_i | input | 1 | Wired-OR shared line from other caches |
| snp_cmd_i | input | 3 | Command observed on the bus |
| snp_addr_i | input | ADDR_W | Address observed on the bus |
| shared_o | output | 1 | This cache keeps a copy of the snooped block |
| supply_o | output | 1 | This cache supplies the snooped Modified block |
| supply_data_o | output | DATA_W | Data supplied with `supply_o` |

## Verification
A snoop lookup and a CPU access can land on the single tag port in the same cycle. The bench provokes this by raising a CPU read that would hit in the very cycle that a foreign read miss appears on the snoop inputs. It judges the outcome by requiring `cpu_done` low in that cycle and high, with the correct data, in the next snoop-free cycle. A second overlap is the controller's own command seen on the snoop inputs while it is master. The bench mirrors the command back during an invalidate, then checks that the line still hits afterwards with the newly written data.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_SHR = 2'd1,
      LS_EXC = 2'd2,
      LS_MOD = 2'd3
   } line_st_t;

   typedef enum logic [2:0] {
      BC_IDLE   = 3'd0,
      BC_RDMISS = 3'd1,
      BC_WRMISS = 3'd2,
      BC_INVAL  = 3'd3,
      BC_WBACK  = 3'd4
   } bus_cmd_t;

   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_ARB   = 2'd1,
      FS_EVICT = 2'd2,
      FS_XFER  = 2'd3
   } fsm_st_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
   import mesi_pkg::*;
#(
   parameter int LINES  = 4,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output line_st_t          rd_state,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic              wr_fill,
   input  logic [IDX_W-1:0]  wr_idx,
   input  line_st_t          wr_state,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data
);
   line_st_t          st_q   [LINES];
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [DATA_W-1:0] data_q [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q[i]   <= LS_INV;
            tag_q[i]  <= '0;
            data_q[i] <= '0;
         end else if (wr_en && wr_idx == IDX_W'(i)) begin
            st_q[i] <= wr_state;
            if (wr_fill) begin
               tag_q[i]  <= wr_tag;
               data_q[i] <= wr_data;
            end
         end
      end
   end

   assign rd_state = st_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
   import mesi_pkg::*;
#(
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16
) (
   input  logic              bus_gnt,
   input  logic [2:0]        snp_cmd,
   input  logic [TAG_W-1:0]  snp_tag,
   input  line_st_t          line_state,
   input  logic [TAG_W-1:0]  line_tag,
   input  logic [DATA_W-1:0] line_data,
   output logic              snp_active,
   output logic              upd_en,
   output line_st_t          upd_state,
   output logic              shared_o,
   output logic              supply_o,
   output logic [DATA_W-1:0] supply_data
);
   logic is_rd, is_wr, is_inv, hit;

   assign is_rd      = snp_cmd == BC_RDMISS;
   assign is_wr      = snp_cmd == BC_WRMISS;
   assign is_inv     = snp_cmd == BC_INVAL;
   assign snp_active = !bus_gnt && (is_rd || is_wr || is_inv);
   assign hit        = snp_active && line_state != LS_INV && line_tag == snp_tag;
   assign upd_en     = hit;
   assign shared_o   = hit && is_rd;
   assign supply_o   = hit && line_state == LS_MOD && (is_rd || is_wr);
   assign supply_data = supply_o ? line_data : '0;

   always_comb begin
      upd_state = line_state;
      if (is_rd) upd_state = LS_SHR;
      else       upd_state = LS_INV;
   end
endmodule

// File: rtl/mesi_cpu_fsm.sv
module mesi_cpu_fsm
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int LINES  = 4,
   localparam int IDX_W = $clog2(LINES),
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              snp_active,
   input  line_st_t          line_state,
   input  logic [TAG_W-1:0]  line_tag,
   input  logic [DATA_W-1:0] line_data,
   input  logic              bus_gnt,
   input  logic              shared_i,
   input  logic [DATA_W-1:0] bus_rdata_i,
   output logic              bus_req,
   output logic [2:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic              wr_en,
   output logic              wr_fill,
   output line_st_t          wr_state,
   output logic [DATA_W-1:0] wr_data
);
   fsm_st_t st_q, st_d;
   logic    hit, owned;

   assign hit   = line_state != LS_INV && line_tag == cpu_addr[ADDR_W-1:IDX_W];
   assign owned = line_state == LS_MOD || line_state == LS_EXC;
   assign bus_req = st_q != FS_IDLE;

   always_comb begin
      st_d      = st_q;
      cpu_done  = 1'b0;
      cpu_rdata = '0;
      bus_cmd   = BC_IDLE;
      bus_addr  = '0;
      bus_data  = '0;
      wr_en     = 1'b0;
      wr_fill   = 1'b0;
      wr_state  = LS_MOD;
      wr_data   = cpu_wdata;
      unique case (st_q)
         FS_IDLE: if (cpu_req && !snp_active) begin
            if (hit && (!cpu_we || owned)) begin
               cpu_done  = 1'b1;
               cpu_rdata = line_data;
               wr_en     = cpu_we;
               wr_fill   = cpu_we;
            end else begin
               st_d = FS_ARB;
            end
         end
         FS_ARB: if (bus_gnt) begin
            st_d = (line_state == LS_MOD && !hit) ? FS_EVICT : FS_XFER;
         end
         FS_EVICT: begin
            bus_cmd  = BC_WBACK;
            bus_addr = {line_tag, cpu_addr[IDX_W-1:0]};
            bus_data = line_data;
            st_d     = FS_XFER;
         end
         FS_XFER: begin
            cpu_done = 1'b1;
            wr_en    = 1'b1;
            wr_fill  = 1'b1;
            bus_addr = cpu_addr;
            st_d     = FS_IDLE;
            if (cpu_we) begin
               bus_cmd = (hit && line_state == LS_SHR) ? BC_INVAL : BC_WRMISS;
            end else begin
               bus_cmd   = BC_RDMISS;
               cpu_rdata = bus_rdata_i;
               wr_data   = bus_rdata_i;
               wr_state  = shared_i ? LS_SHR : LS_EXC;
            end
         end
         default: st_d = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= FS_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int LINES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [2:0]        bus_cmd_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] bus_data_o,
   input  logic [DATA_W-1:0] bus_rdata_i,
   input  logic              shared_i,
   input  logic [2:0]        snp_cmd_i,
   input  logic [ADDR_W-1:0] snp_addr_i,
   output logic              shared_o,
   output logic              supply_o,
   output logic [DATA_W-1:0] supply_data_o
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   line_st_t          rd_state, snp_upd_state, fsm_wr_state, wr_state;
   logic [TAG_W-1:0]  rd_tag;
   logic [DATA_W-1:0] rd_data, fsm_wr_data;
   logic              snp_active, snp_upd, fsm_wr_en, fsm_wr_fill;
   logic [IDX_W-1:0]  rd_idx;

   assign rd_idx   = snp_active ? snp_addr_i[IDX_W-1:0] : cpu_addr[IDX_W-1:0];
   assign wr_state = snp_upd ? snp_upd_state : fsm_wr_state;

   mesi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (rd_idx),
      .rd_state (rd_state),
      .rd_tag   (rd_tag),
      .rd_data  (rd_data),
      .wr_en    (snp_upd || fsm_wr_en),
      .wr_fill  (!snp_upd && fsm_wr_fill),
      .wr_idx   (rd_idx),
      .wr_state (wr_state),
      .wr_tag   (cpu_addr[ADDR_W-1:IDX_W]),
      .wr_data  (fsm_wr_data)
   );

   mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) snoop_i (
      .bus_gnt     (bus_gnt),
      .snp_cmd     (snp_cmd_i),
      .snp_tag     (snp_addr_i[ADDR_W-1:IDX_W]),
      .line_state  (rd_state),
      .line_tag    (rd_tag),
      .line_data   (rd_data),
      .snp_active  (snp_active),
      .upd_en      (snp_upd),
      .upd_state   (snp_upd_state),
      .shared_o    (shared_o),
      .supply_o    (supply_o),
      .supply_data (supply_data_o)
   );

   mesi_cpu_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_req     (cpu_req),
      .cpu_we      (cpu_we),
      .cpu_addr    (cpu_addr),
      .cpu_wdata   (cpu_wdata),
      .cpu_done    (cpu_done),
      .cpu_rdata   (cpu_rdata),
      .snp_active  (snp_active),
      .line_state  (rd_state),
      .line_tag    (rd_tag),
      .line_data   (rd_data),
      .bus_gnt     (bus_gnt),
      .shared_i    (shared_i),
      .bus_rdata_i (bus_rdata_i),
      .bus_req     (bus_req),
      .bus_cmd     (bus_cmd_o),
      .bus_addr    (bus_addr_o),
      .bus_data    (bus_data_o),
      .wr_en       (fsm_wr_en),
      .wr_fill     (fsm_wr_fill),
      .wr_state    (fsm_wr_state),
      .wr_data     (fsm_wr_data)
   );
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_done,
   input logic              bus_req,
   input logic              bus_gnt,
   input logic [2:0]        bus_cmd_o,
   input logic [2:0]        snp_cmd_i,
   input logic              shared_o,
   input logic              supply_o
);
   logic snoop_seen;
   assign snoop_seen = snp_cmd_i == 3'd1 || snp_cmd_i == 3'd2 || snp_cmd_i == 3'd3;

   assert_cmd_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd_o != 3'd0) |-> bus_gnt);

   assert_cmd_under_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd_o != 3'd0) |-> bus_req);

   assert_wb_then_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd_o == 3'd4) |=> (bus_cmd_o == 3'd1 || bus_cmd_o == 3'd2));

   assert_release_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !bus_req);

   assert_snoop_stalls_cpu_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_gnt && cpu_req && snoop_seen) |-> !cpu_done);

   assert_master_ignores_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_gnt |-> (!shared_o && !supply_o));

   assert_supply_only_on_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
      supply_o |-> (snp_cmd_i == 3'd1 || snp_cmd_i == 3'd2));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_done  (cpu_done),
   .bus_req   (bus_req),
   .bus_gnt   (bus_gnt),
   .bus_cmd_o (bus_cmd_o),
   .snp_cmd_i (snp_cmd_i),
   .shared_o  (shared_o),
   .supply_o  (supply_o)
);

// File: tb/mesi_line_ctrl_tb.sv
module mesi_line_ctrl_tb_top;
   localparam int AW = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_done;
   logic [DW-1:0] cpu_rdata;
   logic          bus_req, bus_gnt;
   logic [2:0]    bus_cmd_o;
   logic [AW-1:0] bus_addr_o;
   logic [DW-1:0] bus_data_o, bus_rdata_i, supply_data_o;
   logic          shared_i = 1'b0, shared_o, supply_o;
   logic [2:0]    ext_cmd = 3'd0, snp_cmd_i;
   logic [AW-1:0] ext_addr = '0, snp_addr_i;

   logic [DW-1:0] mem [256];
   int n_rd, n_wr, n_inv, n_wb, checks, fails;
   logic [2:0] prev_cmd;
   bit wb_then_rd;

   always #10 clk = ~clk;

   mesi_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
      .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
      .bus_cmd_o(bus_cmd_o), .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
      .bus_rdata_i(bus_rdata_i), .shared_i(shared_i), .snp_cmd_i(snp_cmd_i),
      .snp_addr_i(snp_addr_i), .shared_o(shared_o), .supply_o(supply_o),
      .supply_data_o(supply_data_o)
   );

   // bus model: own commands are mirrored onto the snoop inputs while granted
   assign snp_cmd_i   = bus_gnt ? bus_cmd_o : ext_cmd;
   assign snp_addr_i  = bus_gnt ? bus_addr_o : ext_addr;
   assign bus_rdata_i = mem[bus_addr_o];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_gnt <= 1'b0; n_rd <= 0; n_wr <= 0; n_inv <= 0; n_wb <= 0;
         prev_cmd <= 3'd0; wb_then_rd <= 1'b0;
      end else begin
         bus_gnt  <= bus_req;
         prev_cmd <= bus_cmd_o;
         if (prev_cmd == 3'd4 && bus_cmd_o == 3'd1) wb_then_rd <= 1'b1;
         case (bus_cmd_o)
            3'd1: n_rd  <= n_rd + 1;
            3'd2: n_wr  <= n_wr + 1;
            3'd3: n_inv <= n_inv + 1;
            3'd4: begin n_wb <= n_wb + 1; mem[bus_addr_o] <= bus_data_o; end
            default: ;
         endcase
         if (supply_o) mem[ext_addr] <= supply_data_o;
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic sh, output logic [DW-1:0] rd);
      int n = 0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; shared_i = sh;
      #5;
      while (!cpu_done && n < 100) begin @(negedge clk); #5; n++; end
      rd = cpu_rdata;
      @(posedge clk); #1;
      cpu_req = 1'b0; shared_i = 1'b0;
   endtask

   task automatic op_chk(input string tag, input logic we, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input logic sh, input logic dchk,
                         input logic [DW-1:0] ed, input int erd, input int ewr,
                         input int einv, input int ewb);
      int r0, w0, i0, b0;
      logic [DW-1:0] rd;
      r0 = n_rd; w0 = n_wr; i0 = n_inv; b0 = n_wb;
      cpu_op(we, a, wd, sh, rd);
      @(negedge clk);
      if (dchk) chk({tag, " rdata"}, 32'(rd), 32'(ed));
      chk({tag, " bus rd/wr/inv/wb"}, {8'(n_rd-r0), 8'(n_wr-w0), 8'(n_inv-i0), 8'(n_wb-b0)},
          {8'(erd), 8'(ewr), 8'(einv), 8'(ewb)});
   endtask

   task automatic snoop_chk(input string tag, input logic [2:0] c, input logic [AW-1:0] a,
                            input logic esh, input logic esup, input logic [DW-1:0] ed);
      @(negedge clk);
      ext_cmd = c; ext_addr = a;
      #5;
      chk({tag, " shared_o"}, 32'(shared_o), 32'(esh));
      chk({tag, " supply_o"}, 32'(supply_o), 32'(esup));
      if (esup) chk({tag, " supply data"}, 32'(supply_data_o), 32'(ed));
      @(negedge clk);
      ext_cmd = 3'd0;
   endtask

   typedef struct packed {
      logic       we;
      logic [7:0] addr;
      logic [15:0] wdata;
      logic       sh;
      logic       dchk;
      logic [15:0] edata;
      logic [3:0] erd, ewr, einv, ewb;
   } vec_t;

   // expectations follow R2..R6 and R8; mem[a] starts as 0x100 + 3*a
   localparam vec_t VEC [12] = '{
      '{1'b0, 8'h10, 16'h0000, 1'b0, 1'b1, 16'h0130, 4'd1, 4'd0, 4'd0, 4'd0}, // R3 R6 fill E
      '{1'b0, 8'h10, 16'h0000, 1'b0, 1'b1, 16'h0130, 4'd0, 4'd0, 4'd0, 4'd0}, // R2
      '{1'b1, 8'h10, 16'hAAAA, 1'b0, 1'b0, 16'h0000, 4'd0, 4'd0, 4'd0, 4'd0}, // R4 E->M
      '{1'b0, 8'h10, 16'h0000, 1'b0, 1'b1, 16'hAAAA, 4'd0, 4'd0, 4'd0, 4'd0}, // R2 R4
      '{1'b0, 8'h21, 16'h0000, 1'b1, 1'b1, 16'h0163, 4'd1, 4'd0, 4'd0, 4'd0}, // R6 fill S
      '{1'b1, 8'h21, 16'h5555, 1'b0, 1'b0, 16'h0000, 4'd0, 4'd0, 4'd1, 4'd0}, // R5
      '{1'b1, 8'h21, 16'h6666, 1'b0, 1'b0, 16'h0000, 4'd0, 4'd0, 4'd0, 4'd0}, // R5 now M
      '{1'b0, 8'h14, 16'h0000, 1'b0, 1'b1, 16'h013C, 4'd1, 4'd0, 4'd0, 4'd1}, // R8 victim
      '{1'b0, 8'h10, 16'h0000, 1'b0, 1'b1, 16'hAAAA, 4'd1, 4'd0, 4'd0, 4'd0}, // R8 data back
      '{1'b1, 8'h32, 16'h1234, 1'b0, 1'b0, 16'h0000, 4'd0, 4'd1, 4'd0, 4'd0}, // R3 wr miss
      '{1'b0, 8'h32, 16'h0000, 1'b0, 1'b1, 16'h1234, 4'd0, 4'd0, 4'd0, 4'd0}, // R3 M
      '{1'b1, 8'h43, 16'h7777, 1'b0, 1'b0, 16'h0000, 4'd0, 4'd1, 4'd0, 4'd0}  // R3
   };

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [DW-1:0] rd;
      for (int i = 0; i < 256; i++) mem[i] = 16'h100 + 16'(3 * i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 bus_req", 32'(bus_req), 0);
      chk("R1 bus_cmd", 32'(bus_cmd_o), 0);
      chk("R1 cpu_done", 32'(cpu_done), 0);
      chk("R1 shared/supply", {shared_o, supply_o}, 0);

      for (int k = 0; k < 12; k++)
         op_chk($sformatf("R1-vec%0d", k), VEC[k].we, VEC[k].addr, VEC[k].wdata, VEC[k].sh,
                VEC[k].dchk, VEC[k].edata, int'(VEC[k].erd), int'(VEC[k].ewr),
                int'(VEC[k].einv), int'(VEC[k].ewb));
      chk("R8 write-back precedes read miss", 32'(wb_then_rd), 1);

      // R9: snooped read miss on Modified 0x32 supplies, line becomes Shared
      snoop_chk("R9 rd on M", 3'd1, 8'h32, 1'b1, 1'b1, 16'h1234);
      chk("R9 memory updated", 32'(mem[8'h32]), 32'h1234);
      op_chk("R9 S after supply", 1'b1, 8'h32, 16'h4321, 1'b0, 1'b0, 16'h0, 0, 0, 1, 0);
      // R7: own invalidate mirrored on snoop inputs must not invalidate the line
      op_chk("R7 own cmd ignored", 1'b0, 8'h32, 16'h0, 1'b0, 1'b1, 16'h4321, 0, 0, 0, 0);
      // R9: snooped write miss on Modified supplies, line becomes Invalid
      snoop_chk("R9 wr on M", 3'd2, 8'h32, 1'b0, 1'b1, 16'h4321);
      op_chk("R9 I after wr snoop", 1'b0, 8'h32, 16'h0, 1'b0, 1'b1, 16'h4321, 1, 0, 0, 0);
      // R10: mismatching tag has no effect
      snoop_chk("R10 tag miss", 3'd3, 8'h20, 1'b0, 1'b0, 16'h0);
      op_chk("R10 line kept", 1'b0, 8'h10, 16'h0, 1'b0, 1'b1, 16'hAAAA, 0, 0, 0, 0);
      // R10: read snoop on Exclusive -> Shared
      snoop_chk("R10 rd on E", 3'd1, 8'h10, 1'b1, 1'b0, 16'h0);
      op_chk("R10 E became S", 1'b1, 8'h10, 16'hBBBB, 1'b0, 1'b0, 16'h0, 0, 0, 1, 0);
      // R10: invalidate on Exclusive 0x32 -> Invalid
      snoop_chk("R10 inv", 3'd3, 8'h32, 1'b0, 1'b0, 16'h0);
      op_chk("R10 I after inv", 1'b0, 8'h32, 16'h0, 1'b0, 1'b1, 16'h4321, 1, 0, 0, 0);

      // R11: snoop and CPU hit in the same cycle -> CPU stalled one cycle
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h10;
      ext_cmd = 3'd1; ext_addr = 8'h55;
      #5;
      chk("R11 stalled under snoop", 32'(cpu_done), 0);
      @(negedge clk);
      ext_cmd = 3'd0;
      #5;
      chk("R11 done after snoop", 32'(cpu_done), 1);
      chk("R11 data after stall", 32'(cpu_rdata), 32'hBBBB);
      @(posedge clk); #1;
      cpu_req = 1'b0;

      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule